// File: doc/BRIEF.md
# Data Address Translation Unit

This block turns a 64-bit virtual data address into a physical address for one load or store at a time. A request chooses one of three paths. A request flagged as physical goes straight through untranslated. When superpage mapping is enabled, a kernel-mode access in a fixed virtual region maps directly onto physical memory. Every other request is checked for a well-formed virtual address and then looked up in a small, fully associative translation buffer tagged with an address-space number.

Every response is registered and appears on the cycle after the request strobe. It carries the physical address, a two-bit fault code and a three-bit status word. A final check sends a machine-check fault for any physical address wider than the implemented 40 bits. Four counters record lookup-path reads and writes, and successful reads and writes. Entries are loaded through a fill port and replaced in round-robin order. Page-table walking and cacheability decode happen elsewhere.

Top module: `xlat_unit`

## Requirements
- R1: A request with `req_phys`=1 uses its virtual address unchanged as the physical address. It skips the validity, superpage and buffer checks and does not touch any counter.
- R2: A request with `req_phys`=0, `spage_ctl[1]`=1 and VA[42:41]=2'b10 takes the superpage path. In kernel mode (`cur_mode`=0) it returns PA = VA[39:0] zero-extended, with fault 0 and status 0.
- R3: A superpage-path request in any mode other than 0 returns fault 2 (access violation), PA 0, and status with bit 1 (violation) set and bit 0 (write) equal to `req_write`.
- R4: On the lookup path, a virtual address whose bits 63:43 are not all equal to bit 42 returns fault 1. Its status has bit 2 (bad address) and bit 1 set, and bit 0 equals `req_write`.
- R5: On the lookup path, a valid address looks up VPN = VA[42:13] together with `cur_asn`. A hit returns PA = {PFN, VA[12:0]}. A miss returns fault 1 with status bit 0 equal to `req_write` and all other status bits 0.
- R6: A hit returns fault 2 when it lacks permission. Permission comes from the entry's read-enable bit for `cur_mode` on a load, or its write-enable bit for `cur_mode` on a store. Status bit 1 is set and bit 0 equals `req_write`.
- R7: When the resulting physical address has any bit above bit 39 set, the response is fault 3 (machine check), with PA 0 and status 0.
- R8: The read and write access counters increment once for each lookup-path load or store, including bad-address requests. The read and write hit counters increment only on a hit that has permission.
- R9: The buffer holds 8 entries. Each fill writes the slot at a round-robin pointer, which starts at slot 0 after reset and advances by one per fill. The ninth fill therefore overwrites the first.
- R10: `rsp_valid` goes high exactly on the cycle after each `req_valid` cycle. Every faulting response carries PA 0. After reset, `rsp_valid` and all counters are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| req_valid | input | 1 | Request strobe |
| req_va | input | 64 | Virtual address |
| req_phys | input | 1 | Address is already physical |
| req_write | input | 1 | 1 = store, 0 = load |
| cur_mode | input | 2 | Privilege mode, 0 = kernel |
| spage_ctl | input | 2 | Superpage control; bit 1 enables the window |
| cur_asn | input | 8 | Current address-space number |
| fill_en | input | 1 | Write one buffer entry |
| fill_vpn | input | 30 | Fill virtual page number |
| fill_asn | input | 8 | Fill address-space number |
| fill_pfn | input | 27 | Fill physical frame number |
| fill_rd_en | input | 4 | Per-mode read enables |
| fill_wr_en | input | 4 | Per-mode write enables |
| rsp_valid | output | 1 | Response strobe |
| rsp_pa | output | 64 | Physical address |
| rsp_fault | output | 2 | 0 none, 1 miss/bad address, 2 violation, 3 machine check |
| rsp_status | output | 3 | Bit 2 bad address, bit 1 violation, bit 0 write |
| rd_access_cnt | output | 16 | Lookup-path loads |
| wr_access_cnt | output | 16 | Lookup-path stores |
| rd_hit_cnt | output | 16 | Successful lookup loads |
| wr_hit_cnt | output | 16 | Successful lookup stores |

## Verification
The bench sends physical requests with high address bits set. A design that masks the bypass address would return success where a machine check is due. It sends superpage-region addresses that are not sign-extended: a design that runs the validity check before choosing the path would report a bad address. The same region with the enable bit cleared must fall through to the lookup path and be counted. Store and load permission are tried in several modes, along with a wrong address-space number. A ninth fill must evict the first entry. A wrong replacement pointer, a permission bit swapped between load and store, or counting of bypass and superpage accesses would each show up as a mismatch against the scoreboard's model.

// File: rtl/xlat_pkg.sv
// Shared types for the address translation unit.
package xlat_pkg;
    typedef enum logic [1:0] {
        FLT_NONE = 2'd0,
        FLT_MISS = 2'd1,
        FLT_ACV  = 2'd2,
        FLT_MCHK = 2'd3
    } fault_e;

    // Status word bit positions
    localparam int ST_WR  = 0;
    localparam int ST_ACV = 1;
    localparam int ST_BAD = 2;
    localparam int ST_W   = 3;

    localparam int MODES = 4;
    localparam logic [1:0] MODE_KERNEL = 2'd0;
endpackage

// File: rtl/xlat_tlb.sv
// Fully associative translation buffer with round-robin fill.
// Assumes software never installs two entries with the same VPN/ASN;
// if it does, the lowest index wins.
module xlat_tlb #(
    parameter int ENTRIES = 8,
    parameter int VPN_W   = 30,
    parameter int ASN_W   = 8,
    parameter int PFN_W   = 27,
    parameter int MODES   = 4
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             fill_en,
    input  logic [VPN_W-1:0] fill_vpn,
    input  logic [ASN_W-1:0] fill_asn,
    input  logic [PFN_W-1:0] fill_pfn,
    input  logic [MODES-1:0] fill_rd,
    input  logic [MODES-1:0] fill_wr,
    input  logic [VPN_W-1:0] lk_vpn,
    input  logic [ASN_W-1:0] lk_asn,
    output logic             lk_hit,
    output logic [PFN_W-1:0] lk_pfn,
    output logic [MODES-1:0] lk_rd,
    output logic [MODES-1:0] lk_wr
);
    localparam int IDX_W = (ENTRIES > 1) ? $clog2(ENTRIES) : 1;

    typedef struct packed {
        logic             vld;
        logic [VPN_W-1:0] vpn;
        logic [ASN_W-1:0] asn;
        logic [PFN_W-1:0] pfn;
        logic [MODES-1:0] rd;
        logic [MODES-1:0] wr;
    } entry_t;

    entry_t             ent [ENTRIES];
    logic [IDX_W-1:0]   rr_ptr;
    logic [ENTRIES-1:0] match;

    // Advance the replacement pointer on each fill, wrapping at ENTRIES
    always_ff @(posedge clk) begin
        if (!rst_n)       rr_ptr <= '0;
        else if (fill_en) rr_ptr <= (rr_ptr == IDX_W'(ENTRIES-1)) ? '0 : rr_ptr + 1'b1;
    end

    for (genvar i = 0; i < ENTRIES; i++) begin : g_ent
        // Hold one entry; clear its valid bit on reset, load it when selected
        always_ff @(posedge clk) begin
            if (!rst_n)
                ent[i].vld <= 1'b0;
            else if (fill_en && rr_ptr == IDX_W'(i))
                ent[i] <= '{vld: 1'b1, vpn: fill_vpn, asn: fill_asn,
                            pfn: fill_pfn, rd: fill_rd, wr: fill_wr};
        end
        assign match[i] = ent[i].vld && ent[i].vpn == lk_vpn && ent[i].asn == lk_asn;
    end

    // Select the lowest matching entry
    always_comb begin
        lk_hit = |match;
        lk_pfn = '0;
        lk_rd  = '0;
        lk_wr  = '0;
        for (int i = ENTRIES-1; i >= 0; i--) begin
            if (match[i]) begin
                lk_pfn = ent[i].pfn;
                lk_rd  = ent[i].rd;
                lk_wr  = ent[i].wr;
            end
        end
    end
endmodule

// File: rtl/xlat_ctr.sv
// Bank of free-running event counters, one increment strobe per counter.
// Assumes wrap-around on overflow is acceptable.
module xlat_ctr #(
    parameter int NUM   = 4,
    parameter int CNT_W = 16
) (
    input  logic                      clk,
    input  logic                      rst_n,
    input  logic [NUM-1:0]            inc,
    output logic [NUM-1:0][CNT_W-1:0] cnt
);
    for (genvar i = 0; i < NUM; i++) begin : g_ctr
        // Count one event per strobed cycle
        always_ff @(posedge clk) begin
            if (!rst_n)      cnt[i] <= '0;
            else if (inc[i]) cnt[i] <= cnt[i] + 1'b1;
        end
    end
endmodule

// File: rtl/xlat_unit.sv
// Data address translation: physical bypass, kernel superpage window,
// or buffer lookup, followed by a physical-width check. One request per
// strobe; the result is registered one cycle later.
module xlat_unit
    import xlat_pkg::*;
#(
    parameter int VA_W    = 64,
    parameter int VS_W    = 43,
    parameter int PA_W    = 40,
    parameter int PG_W    = 13,
    parameter int ASN_W   = 8,
    parameter int ENTRIES = 8,
    parameter int CNT_W   = 16,
    localparam int VPN_W  = VS_W - PG_W,
    localparam int PFN_W  = PA_W - PG_W
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             req_valid,
    input  logic [VA_W-1:0]  req_va,
    input  logic             req_phys,
    input  logic             req_write,
    input  logic [1:0]       cur_mode,
    input  logic [1:0]       spage_ctl,
    input  logic [ASN_W-1:0] cur_asn,
    input  logic             fill_en,
    input  logic [VPN_W-1:0] fill_vpn,
    input  logic [ASN_W-1:0] fill_asn,
    input  logic [PFN_W-1:0] fill_pfn,
    input  logic [3:0]       fill_rd_en,
    input  logic [3:0]       fill_wr_en,
    output logic             rsp_valid,
    output logic [VA_W-1:0]  rsp_pa,
    output logic [1:0]       rsp_fault,
    output logic [2:0]       rsp_status,
    output logic [CNT_W-1:0] rd_access_cnt,
    output logic [CNT_W-1:0] wr_access_cnt,
    output logic [CNT_W-1:0] rd_hit_cnt,
    output logic [CNT_W-1:0] wr_hit_cnt
);
    logic             lk_hit;
    logic [PFN_W-1:0] lk_pfn;
    logic [MODES-1:0] lk_rd, lk_wr;
    logic             sp_sel, va_ok, on_lookup, perm_ok;
    logic [VA_W-1:0]  pa_raw;
    fault_e           nxt_fault;
    logic [ST_W-1:0]  nxt_stat;
    logic [3:0]       ctr_inc;
    logic [3:0][CNT_W-1:0] ctr_val;

    xlat_tlb #(.ENTRIES(ENTRIES), .VPN_W(VPN_W), .ASN_W(ASN_W),
               .PFN_W(PFN_W), .MODES(MODES)) u_tlb (
        .clk(clk), .rst_n(rst_n),
        .fill_en(fill_en), .fill_vpn(fill_vpn), .fill_asn(fill_asn),
        .fill_pfn(fill_pfn), .fill_rd(fill_rd_en), .fill_wr(fill_wr_en),
        .lk_vpn(req_va[VS_W-1:PG_W]), .lk_asn(cur_asn),
        .lk_hit(lk_hit), .lk_pfn(lk_pfn), .lk_rd(lk_rd), .lk_wr(lk_wr)
    );

    assign sp_sel    = spage_ctl[1] && req_va[VS_W-1:VS_W-2] == 2'b10;
    assign va_ok     = (&req_va[VA_W-1:VS_W-1]) || !(|req_va[VA_W-1:VS_W-1]);
    assign on_lookup = !req_phys && !sp_sel;
    assign perm_ok   = req_write ? lk_wr[cur_mode] : lk_rd[cur_mode];

    // Choose the path, form the raw address and any translation fault
    always_comb begin
        pa_raw    = '0;
        nxt_fault = FLT_NONE;
        nxt_stat  = '0;
        if (req_phys) begin
            pa_raw = req_va;
        end else if (sp_sel) begin
            pa_raw = VA_W'(req_va[PA_W-1:0]);
            if (cur_mode != MODE_KERNEL) begin
                nxt_fault      = FLT_ACV;
                nxt_stat[ST_ACV] = 1'b1;
            end
        end else if (!va_ok) begin
            nxt_fault        = FLT_MISS;
            nxt_stat[ST_BAD] = 1'b1;
            nxt_stat[ST_ACV] = 1'b1;
        end else if (!lk_hit) begin
            nxt_fault = FLT_MISS;
        end else if (!perm_ok) begin
            nxt_fault        = FLT_ACV;
            nxt_stat[ST_ACV] = 1'b1;
        end else begin
            pa_raw = VA_W'({lk_pfn, req_va[PG_W-1:0]});
        end
        if (nxt_fault != FLT_NONE) begin
            nxt_stat[ST_WR] = req_write;
        end else if (|pa_raw[VA_W-1:PA_W]) begin
            nxt_fault = FLT_MCHK;
        end
    end

    // Register the response one cycle after the strobe
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            rsp_valid  <= 1'b0;
            rsp_pa     <= '0;
            rsp_fault  <= FLT_NONE;
            rsp_status <= '0;
        end else begin
            rsp_valid <= req_valid;
            if (req_valid) begin
                rsp_pa     <= (nxt_fault == FLT_NONE) ? pa_raw : '0;
                rsp_fault  <= nxt_fault;
                rsp_status <= nxt_stat;
            end
        end
    end

    assign ctr_inc[0] = req_valid && on_lookup && !req_write;
    assign ctr_inc[1] = req_valid && on_lookup &&  req_write;
    assign ctr_inc[2] = ctr_inc[0] && va_ok && lk_hit && perm_ok;
    assign ctr_inc[3] = ctr_inc[1] && va_ok && lk_hit && perm_ok;

    xlat_ctr #(.NUM(4), .CNT_W(CNT_W)) u_ctr (
        .clk(clk), .rst_n(rst_n), .inc(ctr_inc), .cnt(ctr_val)
    );

    assign rd_access_cnt = ctr_val[0];
    assign wr_access_cnt = ctr_val[1];
    assign rd_hit_cnt    = ctr_val[2];
    assign wr_hit_cnt    = ctr_val[3];
endmodule

// File: rtl/xlat_unit_chk.sv
// Temporal checks on the translation unit's ports, bound to every instance.
module xlat_unit_chk #(
    parameter int VA_W  = 64,
    parameter int VS_W  = 43,
    parameter int PA_W  = 40,
    parameter int CNT_W = 16
) (
    input logic             clk,
    input logic             rst_n,
    input logic             req_valid,
    input logic [VA_W-1:0]  req_va,
    input logic             req_phys,
    input logic             req_write,
    input logic [1:0]       cur_mode,
    input logic [1:0]       spage_ctl,
    input logic             rsp_valid,
    input logic [VA_W-1:0]  rsp_pa,
    input logic [1:0]       rsp_fault,
    input logic [2:0]       rsp_status,
    input logic [CNT_W-1:0] rd_access_cnt,
    input logic [CNT_W-1:0] wr_access_cnt,
    input logic [CNT_W-1:0] rd_hit_cnt,
    input logic [CNT_W-1:0] wr_hit_cnt
);
    assert_rsp_follows_req_R10: assert property (@(posedge clk) disable iff (!rst_n)
        req_valid |=> rsp_valid);
    assert_no_rsp_idle_R10: assert property (@(posedge clk) disable iff (!rst_n)
        !req_valid |=> !rsp_valid);
    assert_fault_pa_zero_R10: assert property (@(posedge clk) disable iff (!rst_n)
        (rsp_valid && rsp_fault != 2'd0) |-> rsp_pa == '0);
    assert_bypass_R1: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && req_phys && req_va[VA_W-1:PA_W] == '0)
        |=> (rsp_fault == 2'd0 && rsp_pa == $past(req_va)));
    assert_bypass_mchk_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && req_phys && req_va[VA_W-1:PA_W] != '0) |=> rsp_fault == 2'd3);
    assert_spage_user_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && !req_phys && spage_ctl[1] && req_va[VS_W-1:VS_W-2] == 2'b10
         && cur_mode != 2'd0) |=> (rsp_fault == 2'd2 && rsp_status[1]));
    assert_rd_hit_needs_access_R8: assert property (@(posedge clk) disable iff (!rst_n)
        rd_hit_cnt != $past(rd_hit_cnt) |-> rd_access_cnt != $past(rd_access_cnt));
    assert_wr_hit_needs_access_R8: assert property (@(posedge clk) disable iff (!rst_n)
        wr_hit_cnt != $past(wr_hit_cnt) |-> wr_access_cnt != $past(wr_access_cnt));
    assert_status_write_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && req_write && !req_phys) |=> (rsp_fault == 2'd0 || rsp_fault == 2'd3
                                                   || rsp_status[0]));
endmodule

bind xlat_unit xlat_unit_chk #(.VA_W(VA_W), .VS_W(VS_W), .PA_W(PA_W), .CNT_W(CNT_W)) u_chk (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_va(req_va),
    .req_phys(req_phys), .req_write(req_write), .cur_mode(cur_mode),
    .spage_ctl(spage_ctl), .rsp_valid(rsp_valid), .rsp_pa(rsp_pa),
    .rsp_fault(rsp_fault), .rsp_status(rsp_status),
    .rd_access_cnt(rd_access_cnt), .wr_access_cnt(wr_access_cnt),
    .rd_hit_cnt(rd_hit_cnt), .wr_hit_cnt(wr_hit_cnt)
);

// File: tb/tb_xlat_unit.sv
module tb_xlat_unit;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        req_valid = 1'b0;
    logic [63:0] req_va = '0;
    logic        req_phys = 1'b0;
    logic        req_write = 1'b0;
    logic [1:0]  cur_mode = '0;
    logic [1:0]  spage_ctl = '0;
    logic [7:0]  cur_asn = '0;
    logic        fill_en = 1'b0;
    logic [29:0] fill_vpn = '0;
    logic [7:0]  fill_asn = '0;
    logic [26:0] fill_pfn = '0;
    logic [3:0]  fill_rd_en = '0;
    logic [3:0]  fill_wr_en = '0;
    logic        rsp_valid;
    logic [63:0] rsp_pa;
    logic [1:0]  rsp_fault;
    logic [2:0]  rsp_status;
    logic [15:0] rd_access_cnt, wr_access_cnt, rd_hit_cnt, wr_hit_cnt;

    always #4 clk = ~clk;   // 125 MHz

    xlat_unit dut (.*);

    typedef struct {
        logic [63:0] pa;
        logic [1:0]  flt;
        logic [2:0]  st;
        string       tag;
    } exp_t;

    exp_t sb[$];
    int   n_checks = 0;
    int   n_errors = 0;
    bit   done = 0;

    // Bench-side model of the buffer contents
    logic        m_vld [8];
    logic [29:0] m_vpn [8];
    logic [7:0]  m_asn [8];
    logic [26:0] m_pfn [8];
    logic [3:0]  m_rd  [8];
    logic [3:0]  m_wr  [8];
    int          m_ptr = 0;
    int          e_rda = 0, e_wra = 0, e_rdh = 0, e_wrh = 0;

    task automatic check(string tag, logic [63:0] act, logic [63:0] exp);
        n_checks++;
        if (act !== exp) begin
            n_errors++;
            $display("FAIL %s: actual=%h expected=%h", tag, act, exp);
        end
    endtask

    // Compute the expected response from the requirements
    function automatic exp_t model(logic [63:0] va, bit phys, bit wr, logic [1:0] md,
                                   logic [1:0] ctl, logic [7:0] asn, string tag);
        exp_t e;
        logic [63:0] pa;
        bit hit;
        int k;
        e.tag = tag; e.flt = 0; e.st = 0; pa = 0; hit = 0; k = 0;
        if (phys) pa = va;
        else if (ctl[1] && va[42:41] == 2'b10) begin
            pa = {24'b0, va[39:0]};
            if (md != 0) begin e.flt = 2; e.st = {1'b0, 1'b1, wr}; end
        end else begin
            if (wr) e_wra++; else e_rda++;
            if (!(va[63:43] == '0 && !va[42]) && !(va[63:43] == '1 && va[42])) begin
                e.flt = 1; e.st = {1'b1, 1'b1, wr};
            end else begin
                for (int i = 7; i >= 0; i--)
                    if (m_vld[i] && m_vpn[i] == va[42:13] && m_asn[i] == asn) begin hit = 1; k = i; end
                if (!hit) begin e.flt = 1; e.st = {2'b00, wr}; end
                else if (!(wr ? m_wr[k][md] : m_rd[k][md])) begin e.flt = 2; e.st = {1'b0, 1'b1, wr}; end
                else begin
                    pa = {24'b0, m_pfn[k], va[12:0]};
                    if (wr) e_wrh++; else e_rdh++;
                end
            end
        end
        if (e.flt == 0 && pa[63:40] != 0) e.flt = 3;
        e.pa = (e.flt == 0) ? pa : 64'b0;
        return e;
    endfunction

    // Driver: present one request and push its expected result
    task automatic send(logic [63:0] va, bit phys, bit wr, logic [1:0] md,
                        logic [1:0] ctl, logic [7:0] asn, string tag);
        @(negedge clk);
        req_valid = 1; req_va = va; req_phys = phys; req_write = wr;
        cur_mode = md; spage_ctl = ctl; cur_asn = asn;
        sb.push_back(model(va, phys, wr, md, ctl, asn, tag));
        @(negedge clk);
        req_valid = 0;
    endtask

    task automatic fill(logic [29:0] vpn, logic [7:0] asn, logic [26:0] pfn,
                        logic [3:0] rd, logic [3:0] wr);
        @(negedge clk);
        fill_en = 1; fill_vpn = vpn; fill_asn = asn; fill_pfn = pfn;
        fill_rd_en = rd; fill_wr_en = wr;
        m_vld[m_ptr] = 1; m_vpn[m_ptr] = vpn; m_asn[m_ptr] = asn;
        m_pfn[m_ptr] = pfn; m_rd[m_ptr] = rd; m_wr[m_ptr] = wr;
        m_ptr = (m_ptr + 1) % 8;
        @(negedge clk);
        fill_en = 0;
    endtask

    // Monitor: pop and compare each response as it appears
    always @(negedge clk) begin
        if (rst_n && rsp_valid) begin
            if (sb.size() == 0) check("R10 unexpected response", 1, 0);
            else begin
                exp_t e;
                e = sb.pop_front();
                check({e.tag, " pa"}, rsp_pa, e.pa);
                check({e.tag, " fault"}, 64'(rsp_fault), 64'(e.flt));
                check({e.tag, " status"}, 64'(rsp_status), 64'(e.st));
            end
        end
    end

    task automatic check_counters(string tag);
        check({tag, " R8 rd access"}, 64'(rd_access_cnt), 64'(e_rda));
        check({tag, " R8 wr access"}, 64'(wr_access_cnt), 64'(e_wra));
        check({tag, " R8 rd hit"}, 64'(rd_hit_cnt), 64'(e_rdh));
        check({tag, " R8 wr hit"}, 64'(wr_hit_cnt), 64'(e_wrh));
    endtask

    function automatic logic [63:0] uva(logic [29:0] vpn, logic [12:0] off);
        return {21'b0, vpn, off};
    endfunction

    initial begin
        for (int i = 0; i < 8; i++) m_vld[i] = 0;
        repeat (3) @(negedge clk);
        rst_n = 1;
        @(negedge clk);
        check("R10 reset rsp_valid", 64'(rsp_valid), 0);
        check_counters("reset");

        // R1 bypass, R7 machine check on wide physical address
        send(64'h0000_00AB_CDEF_1234, 1, 0, 2'd3, 2'b10, 8'd0, "R1 bypass");
        send(64'h0000_8000_0000_0000, 1, 1, 2'd0, 2'b00, 8'd0, "R7 bypass wide");
        // R2 superpage in kernel, VA not sign-extended
        send({21'h00F0F0, 2'b10, 41'h1_2345_6789A}, 0, 0, 2'd0, 2'b10, 8'd0, "R2 superpage");
        // R3 superpage in user mode, store
        send({21'h1FFFFF, 2'b10, 41'h0_0000_2000}, 0, 1, 2'd3, 2'b11, 8'd0, "R3 superpage user");
        // Window disabled -> lookup path, bad address (R4) counted (R8)
        send({21'h00F0F0, 2'b10, 41'h1_2345_6789A}, 0, 0, 2'd0, 2'b01, 8'd0, "R4 bad va load");
        send(64'h8000_0000_0000_0000, 0, 1, 2'd0, 2'b00, 8'd0, "R4 bad va store");
        // R5 miss on empty buffer
        send(uva(30'h100, 13'h55), 0, 1, 2'd0, 2'b00, 8'd5, "R5 miss empty");
        // Fills: kernel read/write; user read-only
        fill(30'h100, 8'd5, 27'h7A5_5A5, 4'b0001, 4'b0001);
        fill(30'h200, 8'd5, 27'h000_123, 4'b1111, 4'b0001);
        send(uva(30'h100, 13'h1ABC), 0, 0, 2'd0, 2'b10, 8'd5, "R5 hit load");
        send(uva(30'h100, 13'h0007), 0, 1, 2'd0, 2'b10, 8'd5, "R5 hit store");
        send(uva(30'h100, 13'h0007), 0, 0, 2'd0, 2'b10, 8'd6, "R5 asn mismatch");
        send(uva(30'h100, 13'h0007), 0, 0, 2'd1, 2'b00, 8'd5, "R6 no read perm");
        send(uva(30'h200, 13'h0010), 0, 0, 2'd3, 2'b00, 8'd5, "R6 user read ok");
        send(uva(30'h200, 13'h0010), 0, 1, 2'd3, 2'b00, 8'd5, "R6 user write denied");
        // R9 seven more fills wrap the pointer; the ninth replaces slot 0
        for (int i = 0; i < 7; i++) fill(30'h300 + 30'(i), 8'd5, 27'(i), 4'b1111, 4'b1111);
        send(uva(30'h100, 13'h0), 0, 0, 2'd0, 2'b00, 8'd5, "R9 evicted slot0");
        send(uva(30'h200, 13'h0), 0, 0, 2'd0, 2'b00, 8'd5, "R9 slot1 kept");
        send(uva(30'h306, 13'h4), 0, 1, 2'd2, 2'b00, 8'd5, "R9 newest");
        repeat (2) @(negedge clk);
        check("R10 scoreboard drained", 64'(sb.size()), 0);
        check_counters("final");
        done = 1;
        $display("Result: errors=%0d of %0d checks", n_errors, n_checks);
        $finish;
    end

    initial begin
        repeat (5000) @(posedge clk);
        if (!done) begin
            n_checks++; n_errors++;
            $display("FAIL watchdog: actual=hung expected=done");
            $display("Result: errors=%0d of %0d checks", n_errors, n_checks);
            $finish;
        end
    end
endmodule